// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB LCD panel. A programmable divider derives a pixel rate from the system clock, or passes the system clock straight through. Two position counters step through each line (sync, back porch, active, front porch) and through the lines of a frame in the same order. From these counters the block drives the horizontal and vertical sync pulses, a data-enable strobe and zero-based pixel coordinates. It also packs an incoming 24-bit RGB pixel to the selected panel colour depth.

Software writes the timing fields as plain inputs. Every field except the vertical back porch holds its count minus one. The vertical back porch holds its count as-is, so it may be zero. All line and frame fields are copied into shadow registers at the first pixel of each frame, so a frame that has started always keeps the same geometry. The divider and pixel-clock polarity inputs act at once.

Top module: `lcd_raster_gen`

## Requirements
- R1: `pclk_en` is high for one system cycle out of every `cfg_clkdiv + 2` cycles. When `cfg_clk_bypass` is 1 it is high on every cycle.
- R2: Take N = `cfg_clkdiv + 2` and a phase that counts 0..N-1 and returns to 0 after the `pclk_en` cycle. `pclk_out` is low for phases below N/2 (rounded down) and high for the rest, so data changes while the clock is low. `cfg_clk_inv` = 1 inverts it. In bypass, `pclk_out` holds the value of `cfg_clk_inv`.
- R3: Each line is made of pixel ticks in this order: sync for `hsw+1`, back porch for `hbp+1`, active for `hact+1`, front porch for `hfp+1`.
- R4: Each frame is made of lines in this order: sync for `vsw+1`, back porch for exactly `vbp` lines (0 is allowed), active for `vact+1`, front porch for `vfp+1`. The line counter advances on the last pixel tick of a line.
- R5: With its low-polarity bit at 0, a sync output is high during its sync interval and low otherwise. With the bit at 1, that output is inverted.
- R6: `de` is high only when both the pixel position and the line position are inside their active intervals. It is never high during a sync interval.
- R7: While `de` is high, `pix_x` and `pix_y` give the offset from the first active pixel and the first active line. While `de` is low, both are 0.
- R8: `pix_in` is {R[7:0],G[7:0],B[7:0]}. `pix_out` is right-aligned according to `cfg_depth`: 00 gives the 24-bit value unchanged; 01 gives {R[7:2],G[7:2],B[7:2]}; 10 gives {R[7:3],G[7:2],B[7:3]}; 11 gives {R[7:4],G[7:4],B[7:4]}. Unused upper bits are 0, and `pix_out` is 0 while `de` is low.
- R9: The line and frame fields, the sync polarities and the depth are sampled only at the first pixel tick of a frame. Changing them mid-frame has no effect until the next frame. The divider, bypass and clock-inversion inputs act immediately.
- R10: During and after reset, until the first pixel tick, `hsync`, `vsync`, `de`, `pix_x`, `pix_y` and `pix_out` are 0. The first pixel tick starts a frame at position (0,0) with the current fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clkdiv | input | DIV_W | Divider field; the period is value+2 |
| cfg_clk_bypass | input | 1 | Use the system clock as the pixel rate |
| cfg_clk_inv | input | 1 | Invert the pixel clock output |
| cfg_hsw | input | H_W | Horizontal sync width minus one |
| cfg_hbp | input | H_W | Horizontal back porch minus one |
| cfg_hact | input | H_W | Pixels per line minus one |
| cfg_hfp | input | H_W | Horizontal front porch minus one |
| cfg_vsw | input | V_W | Vertical sync width minus one |
| cfg_vbp | input | V_W | Vertical back porch, in lines, as-is |
| cfg_vact | input | V_W | Lines per frame minus one |
| cfg_vfp | input | V_W | Vertical front porch minus one |
| cfg_hs_low | input | 1 | Horizontal sync active-low |
| cfg_vs_low | input | 1 | Vertical sync active-low |
| cfg_depth | input | 2 | Output colour depth code |
| pix_in | input | 24 | Incoming RGB888 pixel |
| pclk_en | output | 1 | Pixel tick strobe |
| pclk_out | output | 1 | Pixel clock level for the panel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | H_W | Active column |
| pix_y | output | V_W | Active row |
| pix_out | output | 24 | Packed pixel data |

## Verification
The hardest situation to reach is a field change that arrives in the middle of a frame. The old geometry has to hold until the exact tick that wraps the frame, and the new geometry has to take over on that same tick. The stimulus changes the porches, the active size, both polarities and the depth a few dozen cycles into a frame. It then changes the divider and bypass without regard to frame position. A behavioural model follows, cycle by cycle, every edge where the divider phase and the frame wrap fall together. The model also covers a zero vertical back porch and an odd divider period.

// File: rtl/lrg_pkg.sv
package lrg_pkg;
   localparam int CH_W  = 8;
   localparam int PIX_W = 3 * CH_W;

   typedef enum logic [1:0] {
      DEPTH_24 = 2'b00,
      DEPTH_18 = 2'b01,
      DEPTH_16 = 2'b10,
      DEPTH_12 = 2'b11
   } depth_e;
endpackage

// File: rtl/lrg_pixdiv.sv
module lrg_pixdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_field,
   input  logic             bypass,
   input  logic             clk_inv,
   output logic             tick,
   output logic             pclk
);
   localparam int PH_W = DIV_W + 1;

   logic [PH_W-1:0] ph;
   logic [PH_W-1:0] ph_last;
   logic [PH_W-1:0] ph_half;

   assign ph_last = PH_W'(div_field) + PH_W'(1);
   assign ph_half = (PH_W'(div_field) + PH_W'(2)) >> 1;
   assign tick    = bypass | (ph >= ph_last);
   assign pclk    = bypass ? clk_inv : ((ph >= ph_half) ^ clk_inv);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ph <= '0;
      else if (tick)  ph <= '0;
      else            ph <= ph + PH_W'(1);
   end

   // R1
   div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !bypass) |=> (!tick || bypass));
endmodule

// File: rtl/lrg_timing.sv
module lrg_timing #(
   parameter int H_W = 10,
   parameter int V_W = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic [H_W-1:0] hsw,
   input  logic [H_W-1:0] hbp,
   input  logic [H_W-1:0] hact,
   input  logic [H_W-1:0] hfp,
   input  logic [V_W-1:0] vsw,
   input  logic [V_W-1:0] vbp,
   input  logic [V_W-1:0] vact,
   input  logic [V_W-1:0] vfp,
   input  logic           hs_low,
   input  logic           vs_low,
   input  logic [1:0]     depth,
   output logic           hsync,
   output logic           vsync,
   output logic           de,
   output logic [H_W-1:0] x,
   output logic [V_W-1:0] y,
   output logic [1:0]     depth_q
);
   localparam int HC_W = H_W + 2;
   localparam int VC_W = V_W + 2;

   logic            run;
   logic [HC_W-1:0] hc;
   logic [VC_W-1:0] vc;
   logic [H_W-1:0]  sh_hsw, sh_hbp, sh_hact, sh_hfp;
   logic [V_W-1:0]  sh_vsw, sh_vbp, sh_vact, sh_vfp;
   logic            sh_hs_low, sh_vs_low;

   logic [HC_W-1:0] h_bp0, h_act0, h_fp0, h_last;
   logic [VC_W-1:0] v_bp0, v_act0, v_fp0, v_last;
   logic            line_end, frame_end, h_in, v_in;

   // interval boundaries from the shadow fields
   assign h_bp0  = HC_W'(sh_hsw) + HC_W'(1);
   assign h_act0 = h_bp0 + HC_W'(sh_hbp) + HC_W'(1);
   assign h_fp0  = h_act0 + HC_W'(sh_hact) + HC_W'(1);
   assign h_last = h_fp0 + HC_W'(sh_hfp);
   assign v_bp0  = VC_W'(sh_vsw) + VC_W'(1);
   assign v_act0 = v_bp0 + VC_W'(sh_vbp);
   assign v_fp0  = v_act0 + VC_W'(sh_vact) + VC_W'(1);
   assign v_last = v_fp0 + VC_W'(sh_vfp);

   assign line_end  = (hc == h_last);
   assign frame_end = line_end && (vc == v_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         hc        <= '0;
         vc        <= '0;
         sh_hsw    <= '0;
         sh_hbp    <= '0;
         sh_hact   <= '0;
         sh_hfp    <= '0;
         sh_vsw    <= '0;
         sh_vbp    <= '0;
         sh_vact   <= '0;
         sh_vfp    <= '0;
         sh_hs_low <= 1'b0;
         sh_vs_low <= 1'b0;
         depth_q   <= '0;
      end else if (tick) begin
         if (!run || frame_end) begin
            run       <= 1'b1;
            hc        <= '0;
            vc        <= '0;
            sh_hsw    <= hsw;
            sh_hbp    <= hbp;
            sh_hact   <= hact;
            sh_hfp    <= hfp;
            sh_vsw    <= vsw;
            sh_vbp    <= vbp;
            sh_vact   <= vact;
            sh_vfp    <= vfp;
            sh_hs_low <= hs_low;
            sh_vs_low <= vs_low;
            depth_q   <= depth;
         end else if (line_end) begin
            hc <= '0;
            vc <= vc + VC_W'(1);
         end else begin
            hc <= hc + HC_W'(1);
         end
      end
   end

   assign h_in  = (hc >= h_act0) && (hc < h_fp0);
   assign v_in  = (vc >= v_act0) && (vc < v_fp0);
   assign de    = run && h_in && v_in;
   assign hsync = (run && (hc < h_bp0)) ^ sh_hs_low;
   assign vsync = (run && (vc < v_bp0)) ^ sh_vs_low;
   assign x     = de ? H_W'(hc - h_act0) : '0;
   assign y     = de ? V_W'(vc - v_act0) : '0;

   // R6
   de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> ((hsync == sh_hs_low) && (vsync == sh_vs_low)));

   // R3
   pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(hc) && $stable(vc)));

   // R7
   x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && de && !line_end) |=> (!de || (x == $past(x) + 1'b1)));

   // R9
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !(tick && frame_end)) |=>
         ($stable(sh_hact) && $stable(sh_vbp) && $stable(sh_hs_low) && $stable(depth_q)));
endmodule

// File: rtl/lrg_fmt.sv
module lrg_fmt
   import lrg_pkg::*;
(
   input  logic             de,
   input  logic [1:0]       depth,
   input  logic [PIX_W-1:0] pix_in,
   output logic [PIX_W-1:0] pix_out
);
   logic [CH_W-1:0] ch [3];

   // channel 0 = blue (LSB), 1 = green, 2 = red
   for (genvar c = 0; c < 3; c++) begin : g_ch
      assign ch[c] = pix_in[c*CH_W +: CH_W];
   end

   always_comb begin
      pix_out = '0;
      if (de) begin
         case (depth_e'(depth))
            DEPTH_24: pix_out = pix_in;
            DEPTH_18: pix_out = PIX_W'({ch[2][7:2], ch[1][7:2], ch[0][7:2]});
            DEPTH_16: pix_out = PIX_W'({ch[2][7:3], ch[1][7:2], ch[0][7:3]});
            default:  pix_out = PIX_W'({ch[2][7:4], ch[1][7:4], ch[0][7:4]});
         endcase
      end
   end
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
   import lrg_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int H_W   = 10,
   parameter int V_W   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_clkdiv,
   input  logic             cfg_clk_bypass,
   input  logic             cfg_clk_inv,
   input  logic [H_W-1:0]   cfg_hsw,
   input  logic [H_W-1:0]   cfg_hbp,
   input  logic [H_W-1:0]   cfg_hact,
   input  logic [H_W-1:0]   cfg_hfp,
   input  logic [V_W-1:0]   cfg_vsw,
   input  logic [V_W-1:0]   cfg_vbp,
   input  logic [V_W-1:0]   cfg_vact,
   input  logic [V_W-1:0]   cfg_vfp,
   input  logic             cfg_hs_low,
   input  logic             cfg_vs_low,
   input  logic [1:0]       cfg_depth,
   input  logic [23:0]      pix_in,
   output logic             pclk_en,
   output logic             pclk_out,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic [H_W-1:0]   pix_x,
   output logic [V_W-1:0]   pix_y,
   output logic [23:0]      pix_out
);
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("lcd_raster_gen: DIV_W out of range");
   end
   if (H_W < 2 || V_W < 2) begin : g_bad_dim
      $error("lcd_raster_gen: H_W and V_W must be at least 2");
   end
   if (PIX_W != 24) begin : g_bad_pix
      $error("lcd_raster_gen: pixel width must be 24");
   end

   logic       tick;
   logic [1:0] depth_q;

   lrg_pixdiv #(.DIV_W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_field (cfg_clkdiv),
      .bypass    (cfg_clk_bypass),
      .clk_inv   (cfg_clk_inv),
      .tick      (tick),
      .pclk      (pclk_out)
   );

   lrg_timing #(.H_W(H_W), .V_W(V_W)) u_tim (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .hsw     (cfg_hsw),
      .hbp     (cfg_hbp),
      .hact    (cfg_hact),
      .hfp     (cfg_hfp),
      .vsw     (cfg_vsw),
      .vbp     (cfg_vbp),
      .vact    (cfg_vact),
      .vfp     (cfg_vfp),
      .hs_low  (cfg_hs_low),
      .vs_low  (cfg_vs_low),
      .depth   (cfg_depth),
      .hsync   (hsync),
      .vsync   (vsync),
      .de      (de),
      .x       (pix_x),
      .y       (pix_y),
      .depth_q (depth_q)
   );

   lrg_fmt u_fmt (
      .de      (de),
      .depth   (depth_q),
      .pix_in  (pix_in),
      .pix_out (pix_out)
   );

   assign pclk_en = tick;

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> ((pix_x == '0) && (pix_y == '0) && (pix_out == '0)));
endmodule

// File: tb/lcd_raster_gen_bench.sv
module lcd_raster_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int HW = 10;
   localparam int VW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] cfg_clkdiv = '0;
   logic cfg_clk_bypass = 1'b0, cfg_clk_inv = 1'b0;
   logic [HW-1:0] cfg_hsw = '0, cfg_hbp = '0, cfg_hact = '0, cfg_hfp = '0;
   logic [VW-1:0] cfg_vsw = '0, cfg_vbp = '0, cfg_vact = '0, cfg_vfp = '0;
   logic cfg_hs_low = 1'b0, cfg_vs_low = 1'b0;
   logic [1:0] cfg_depth = 2'b00;
   logic [23:0] pix_in = '0;
   logic pclk_en, pclk_out, hsync, vsync, de;
   logic [HW-1:0] pix_x;
   logic [VW-1:0] pix_y;
   logic [23:0] pix_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcd_raster_gen #(.DIV_W(DW), .H_W(HW), .V_W(VW)) u_lcd_raster_gen (
      .clk(clk), .rst_n(rst_n), .cfg_clkdiv(cfg_clkdiv),
      .cfg_clk_bypass(cfg_clk_bypass), .cfg_clk_inv(cfg_clk_inv),
      .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hfp(cfg_hfp),
      .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
      .cfg_hs_low(cfg_hs_low), .cfg_vs_low(cfg_vs_low), .cfg_depth(cfg_depth),
      .pix_in(pix_in), .pclk_en(pclk_en), .pclk_out(pclk_out), .hsync(hsync),
      .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y), .pix_out(pix_out));

   // behavioural reference state
   int m_ph, m_run, m_hc, m_vc;
   int s_hsw, s_hbp, s_hact, s_hfp, s_vsw, s_vbp, s_vact, s_vfp;
   int s_hsl, s_vsl, s_depth;
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(string tag, string name, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, name, act, exp, $time);
      end
   endtask

   function automatic int m_tick();
      return (cfg_clk_bypass || (m_ph >= int'(cfg_clkdiv) + 1)) ? 1 : 0;
   endfunction

   task automatic model_reset();
      m_ph = 0; m_run = 0; m_hc = 0; m_vc = 0;
      s_hsw = 0; s_hbp = 0; s_hact = 0; s_hfp = 0;
      s_vsw = 0; s_vbp = 0; s_vact = 0; s_vfp = 0;
      s_hsl = 0; s_vsl = 0; s_depth = 0;
   endtask

   task automatic model_update();
      int t, line_len, frame_lines;
      if (!rst_n) begin
         model_reset();
         return;
      end
      t = m_tick();
      m_ph = t ? 0 : m_ph + 1;
      if (t) begin
         line_len    = s_hsw + s_hbp + s_hact + s_hfp + 4;
         frame_lines = s_vsw + s_vbp + s_vact + s_vfp + 3;
         if (!m_run || (m_hc == line_len - 1 && m_vc == frame_lines - 1)) begin
            m_run = 1; m_hc = 0; m_vc = 0;
            s_hsw = cfg_hsw; s_hbp = cfg_hbp; s_hact = cfg_hact; s_hfp = cfg_hfp;
            s_vsw = cfg_vsw; s_vbp = cfg_vbp; s_vact = cfg_vact; s_vfp = cfg_vfp;
            s_hsl = cfg_hs_low; s_vsl = cfg_vs_low; s_depth = cfg_depth;
         end else if (m_hc == line_len - 1) begin
            m_hc = 0; m_vc++;
         end else begin
            m_hc++;
         end
      end
   endtask

   task automatic compare_all();
      int n, e_pclk, hs0, hs1, ve0, ve1, e_de, e_px, r, g, b;
      n = int'(cfg_clkdiv) + 2;
      if (cfg_clk_bypass) e_pclk = cfg_clk_inv;
      else e_pclk = ((m_ph >= n / 2) ? 1 : 0) ^ int'(cfg_clk_inv);
      hs0 = s_hsw + 1 + s_hbp + 1;
      hs1 = hs0 + s_hact + 1;
      ve0 = s_vsw + 1 + s_vbp;
      ve1 = ve0 + s_vact + 1;
      e_de = (m_run && m_hc >= hs0 && m_hc < hs1 && m_vc >= ve0 && m_vc < ve1) ? 1 : 0;
      r = int'(pix_in[23:16]); g = int'(pix_in[15:8]); b = int'(pix_in[7:0]);
      case (s_depth)
         0: e_px = int'(pix_in);
         1: e_px = ((r >> 2) << 12) | ((g >> 2) << 6) | (b >> 2);
         2: e_px = ((r >> 3) << 11) | ((g >> 2) << 5) | (b >> 3);
         default: e_px = ((r >> 4) << 8) | ((g >> 4) << 4) | (b >> 4);
      endcase
      if (!e_de) e_px = 0;
      chk("R1", "pclk_en", int'(pclk_en), m_tick());
      chk("R2", "pclk_out", int'(pclk_out), e_pclk);
      chk("R3,R5", "hsync", int'(hsync), ((m_run && m_hc < s_hsw + 1) ? 1 : 0) ^ s_hsl);
      chk("R4,R5", "vsync", int'(vsync), ((m_run && m_vc < s_vsw + 1) ? 1 : 0) ^ s_vsl);
      chk("R6", "de", int'(de), e_de);
      chk("R7", "pix_x", int'(pix_x), e_de ? m_hc - hs0 : 0);
      chk("R7", "pix_y", int'(pix_y), e_de ? m_vc - ve0 : 0);
      chk("R8", "pix_out", int'(pix_out), e_px);
   endtask

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_update();
         @(negedge clk);
         compare_all();
         pix_in = 24'($urandom);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      model_reset();
      cfg_hsw = 1; cfg_hbp = 1; cfg_hact = 3; cfg_hfp = 0;
      cfg_vsw = 0; cfg_vbp = 0; cfg_vact = 1; cfg_vfp = 0;
      pix_in = 24'hA5C3_7E;
      // R10: reset state, outputs quiet before the first tick
      @(negedge clk);
      compare_all();
      chk("R10", "de_in_reset", int'(de), 0);
      chk("R10", "hsync_in_reset", int'(hsync), 0);
      cyc(3);
      rst_n = 1'b1;
      // R1 R3 R4 R6 R7 R8: base geometry, divide by 2, zero vertical back porch (R4)
      cyc(250);
      // R9: mid-frame change of geometry, polarity and depth
      cyc(30);
      cfg_hact = 5; cfg_vbp = 2; cfg_hs_low = 1; cfg_vs_low = 1; cfg_depth = 2'b11;
      cyc(300);
      // R1 R2: odd divider period with inverted pixel clock, applied live (R9)
      cfg_clkdiv = 3; cfg_clk_inv = 1; cfg_depth = 2'b01;
      cyc(600);
      // R1 R2: bypass, wider sync and front porch, 16-bit packing
      cfg_clk_bypass = 1; cfg_depth = 2'b10; cfg_vsw = 2; cfg_hfp = 2; cfg_hs_low = 0;
      cyc(300);
      // R4: back to zero vertical back porch, divide by 3, 24-bit
      cfg_clk_bypass = 0; cfg_clkdiv = 1; cfg_clk_inv = 0; cfg_vbp = 0;
      cfg_depth = 2'b00; cfg_vs_low = 0;
      cyc(300);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end
endmodule